// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller. It serves 116 pins spread over five bank slots. Banks 0 and 1 hold 26 pins each, slot 2 is empty, and banks 3 and 4 hold 32 pins each. Global pin numbers run without gaps across the populated banks. Software reaches it over a plain 32-bit register bus. A request is one cycle of `req_valid` with an address, a write flag and write data. The answer arrives on the next cycle as `rsp_valid` with `rsp_rdata`.

Each bank has its own set of registers: an output value, a direction and an output enable, plus a read-only view of the synchronized pin inputs. Output values are written through two half-word ports, one for pins 0-15 and one for pins 16-31. Each port carries a per-pin mask in its upper 16 bits, so one pin can be changed without a read-modify-write sequence. Pins 7 and 8 of bank 0 are tied to output direction.

The response path is a two-state machine. In `ST_IDLE` no response is pending. The transition `req_accept` (taken when `req_valid` is high) moves it to `ST_ACK`, where `rsp_valid` is asserted. From `ST_ACK` the transition `req_accept` stays in `ST_ACK`, and `req_none` (no request) returns to `ST_IDLE`. Because `req_accept` leaves from either state, back-to-back requests are answered in back-to-back cycles.

Top module: `gpio_banked`

## Requirements
- R1: A request accepted on a clock edge gives `rsp_valid` = 1 during the following cycle only, unless a further request follows. A write's response carries `rsp_rdata` = 0. A read's response carries the addressed register value.
- R2: A write to byte offset 8*b (bank b, low half) updates output bit i (i = 0..15) to `req_wdata[i]` only when `req_wdata[16+i]` = 0. A mask bit of 1 leaves that output bit unchanged.
- R3: Offset 8*b+4 is the high half. It applies the same masking to output bits 16..31 using data bits 15:0. A read of either half returns that half's 16 output bits in `rsp_rdata[15:0]` and zeros in bits 31:16.
- R4: Offset 0x060+4*b reads the bank's pin inputs, with bit i = pin i of the bank. Inputs pass two synchronizing flops. A read whose request is sampled at the first or second edge after a pin change returns the old value. A read sampled at the third edge returns the new value.
- R5: Offset 0x204+0x40*b is the direction register, where bit value 1 means output. It reads back as written.
- R6: Offset 0x208+0x40*b is the output-enable register. `pin_oe` for a pin is 1 only when both its direction and output-enable bits are 1. `pin_out` always carries the stored output bit.
- R7: Global pin n maps to bank-local pins as follows: 0..25 to bank 0, 26..51 to bank 1, 52..83 to bank 3, and 84..115 to bank 4. Each bank's pin 0 lands at global 0, 26, 52 and 84 respectively.
- R8: Direction bits 7 and 8 of bank 0 always read 1. Writes of 0 to them are ignored.
- R9: Register bits for pins a bank lacks read 0 and ignore writes. Every address of slot 2 and every unmapped address reads 0, and writes to them change no output.
- R10: Reset (`rst_n` low, asynchronous) clears all output, direction and output-enable bits except the forced bank-0 direction bits, and clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pin_in | input | 116 | Pad input levels, global pin order |
| pin_out | output | 116 | Stored output value per pin |
| pin_oe | output | 116 | Pad driver enable per pin |

## Verification
The bench checks that a set mask bit protects its pin and that a fully set mask changes nothing. A design that inverted the mask sense, or shifted the high half by the wrong amount, would corrupt bits or leave them unchanged. It checks the width edges of the 26-pin banks, the empty slot and unmapped offsets. A decode that leaked into missing bits or onto slot 2 would return non-zero data there. It checks that clearing the forced bank-0 direction bits has no effect, and that `pin_oe` requires both direction and enable. It times the input path to the exact edge, which exposes a synchronizer with too few or too many stages.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int NUM_BANKS = 5;
    localparam int REG_W     = 32;
    localparam int HALF_W    = 16;

    localparam int DATA_BASE   = 'h000;
    localparam int DATA_STRIDE = 'h008;
    localparam int IN_BASE     = 'h060;
    localparam int IN_STRIDE   = 'h004;
    localparam int DIR_BASE    = 'h204;
    localparam int OE_BASE     = 'h208;
    localparam int CFG_STRIDE  = 'h040;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } rsp_state_e;

    function automatic int bank_width(int b);
        case (b)
            0, 1:    return 26;
            3, 4:    return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int bank_base(int b);
        int s;
        s = 0;
        for (int i = 0; i < b; i++) s += bank_width(i);
        return s;
    endfunction

    localparam int NUM_PINS = bank_base(NUM_BANKS);

    // Direction bits tied to output in a bank
    function automatic logic [REG_W-1:0] forced_dir(int b);
        return (b == 0) ? 32'h0000_0180 : 32'h0;
    endfunction

    function automatic int lo_addr(int b);  return DATA_BASE + DATA_STRIDE * b;     endfunction
    function automatic int hi_addr(int b);  return DATA_BASE + DATA_STRIDE * b + 4; endfunction
    function automatic int in_addr(int b);  return IN_BASE + IN_STRIDE * b;         endfunction
    function automatic int dir_addr(int b); return DIR_BASE + CFG_STRIDE * b;       endfunction
    function automatic int oe_addr(int b);  return OE_BASE + CFG_STRIDE * b;        endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_banked_pkg::*;
#(
    parameter int               WIDTH  = 32,
    parameter logic [REG_W-1:0] FORCED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_dir,
    input  logic             wr_oe,
    input  logic [REG_W-1:0] wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [REG_W-1:0] out_q,
    output logic [REG_W-1:0] dir_q,
    output logic [REG_W-1:0] oe_q,
    output logic [REG_W-1:0] din,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    localparam logic [REG_W-1:0] VALID =
        (WIDTH >= REG_W) ? {REG_W{1'b1}} : REG_W'((64'd1 << WIDTH) - 64'd1);
    localparam logic [REG_W-1:0] FORCE_V = FORCED & VALID;

    logic [REG_W-1:0] out_d;
    logic [WIDTH-1:0] sync_q;

    // Masked half-word update: mask bit 0 lets the data bit through
    always_comb begin
        out_d = out_q;
        for (int i = 0; i < HALF_W; i++) begin
            if (wr_lo && !wdata[HALF_W+i]) out_d[i]        = wdata[i];
            if (wr_hi && !wdata[HALF_W+i]) out_d[HALF_W+i] = wdata[i];
        end
        out_d = out_d & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= FORCE_V;
            oe_q  <= '0;
        end else begin
            out_q <= out_d;
            if (wr_dir) dir_q <= (wdata | FORCE_V) & VALID;
            if (wr_oe)  oe_q  <= wdata & VALID;
        end
    end

    gpio_sync #(.W(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    assign din     = REG_W'(sync_q);
    assign pad_out = out_q[WIDTH-1:0];
    assign pad_oe  = dir_q[WIDTH-1:0] & oe_q[WIDTH-1:0];
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [REG_W-1:0]    req_wdata,
    output logic                rsp_valid,
    output logic [REG_W-1:0]    rsp_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic [REG_W-1:0] out_a [NUM_BANKS];
    logic [REG_W-1:0] dir_a [NUM_BANKS];
    logic [REG_W-1:0] oe_a  [NUM_BANKS];
    logic [REG_W-1:0] din_a [NUM_BANKS];

    logic       wr_go;
    int         addr_i;
    logic [REG_W-1:0] rd_mux, rdata_q;
    rsp_state_e state_q, state_d;

    assign wr_go  = req_valid && req_we;
    assign addr_i = int'(req_addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int W    = bank_width(b);
        localparam int BASE = bank_base(b);
        if (W > 0) begin : g_pop
            gpio_bank_regs #(
                .WIDTH  (W),
                .FORCED (forced_dir(b))
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_lo   (wr_go && addr_i == lo_addr(b)),
                .wr_hi   (wr_go && addr_i == hi_addr(b)),
                .wr_dir  (wr_go && addr_i == dir_addr(b)),
                .wr_oe   (wr_go && addr_i == oe_addr(b)),
                .wdata   (req_wdata),
                .pad_in  (pin_in[BASE +: W]),
                .out_q   (out_a[b]),
                .dir_q   (dir_a[b]),
                .oe_q    (oe_a[b]),
                .din     (din_a[b]),
                .pad_out (pin_out[BASE +: W]),
                .pad_oe  (pin_oe[BASE +: W])
            );
        end else begin : g_empty
            assign out_a[b] = '0;
            assign dir_a[b] = '0;
            assign oe_a[b]  = '0;
            assign din_a[b] = '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == lo_addr(b))  rd_mux = {{HALF_W{1'b0}}, out_a[b][HALF_W-1:0]};
            if (addr_i == hi_addr(b))  rd_mux = {{HALF_W{1'b0}}, out_a[b][REG_W-1:HALF_W]};
            if (addr_i == in_addr(b))  rd_mux = din_a[b];
            if (addr_i == dir_addr(b)) rd_mux = dir_a[b];
            if (addr_i == oe_addr(b))  rd_mux = oe_a[b];
        end
    end

    // Response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ACK;
            ST_ACK:  state_d = req_valid ? ST_ACK : ST_IDLE;
        endcase
    end

    // Response data and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rdata_q <= '0;
        else if (req_valid && !req_we)  rdata_q <= rd_mux;
        else                            rdata_q <= '0;
    end

    assign rsp_valid = (state_q == ST_ACK);
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
    parameter int ADDR_W = 16,
    parameter int NPINS  = 116
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we) |=> (rsp_rdata == 32'h0));

    a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_addr == ADDR_W'(0) && req_wdata[16])
        |=> $stable(pin_out[0]));

    a_r9_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_addr == ADDR_W'('h10))
        |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r6_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(req_valid && req_we));
endmodule

bind gpio_banked gpio_banked_chk #(
    .ADDR_W (ADDR_W),
    .NPINS  (gpio_banked_pkg::NUM_PINS)
) u_chk (.*);

// File: tb/gpio_banked_tb_top.sv
module gpio_banked_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 116;
    localparam int NV = 23;

    // {req_tag[3:0], we, addr[15:0], wdata[31:0], expect[31:0]}
    localparam logic [84:0] VEC [NV] = '{
        {4'd2,  1'b1, 16'h0000, 32'h0000_A5A5, 32'h0},          // R2 all mask clear
        {4'd2,  1'b0, 16'h0000, 32'h0,         32'h0000_A5A5},
        {4'd2,  1'b1, 16'h0000, 32'hFFFE_0000, 32'h0},          // R2 only pin 0 open
        {4'd2,  1'b0, 16'h0000, 32'h0,         32'h0000_A5A4},
        {4'd3,  1'b1, 16'h0004, 32'h0000_FFFF, 32'h0},          // R3 high half
        {4'd9,  1'b0, 16'h0004, 32'h0,         32'h0000_03FF},  // R9 bank width 26
        {4'd2,  1'b1, 16'h0004, 32'hFFFF_0000, 32'h0},          // R2 all masked
        {4'd2,  1'b0, 16'h0004, 32'h0,         32'h0000_03FF},
        {4'd8,  1'b1, 16'h0204, 32'h0,         32'h0},          // R8 try clearing 7,8
        {4'd8,  1'b0, 16'h0204, 32'h0,         32'h0000_0180},
        {4'd5,  1'b1, 16'h0204, 32'hFFFF_FFFF, 32'h0},          // R5
        {4'd5,  1'b0, 16'h0204, 32'h0,         32'h03FF_FFFF},
        {4'd3,  1'b1, 16'h001C, 32'h0000_1234, 32'h0},          // R3 bank 3 high
        {4'd3,  1'b0, 16'h001C, 32'h0,         32'h0000_1234},
        {4'd9,  1'b1, 16'h0010, 32'h0000_FFFF, 32'h0},          // R9 empty slot
        {4'd9,  1'b0, 16'h0010, 32'h0,         32'h0},
        {4'd9,  1'b0, 16'h0400, 32'h0,         32'h0},          // R9 unmapped
        {4'd6,  1'b1, 16'h02C8, 32'hFFFF_FFFF, 32'h0},          // R6
        {4'd6,  1'b0, 16'h02C8, 32'h0,         32'hFFFF_FFFF},
        {4'd9,  1'b1, 16'h0248, 32'hFFFF_FFFF, 32'h0},          // R9
        {4'd9,  1'b0, 16'h0248, 32'h0,         32'h03FF_FFFF},
        {4'd5,  1'b1, 16'h02C4, 32'h0000_000F, 32'h0},          // R5
        {4'd5,  1'b0, 16'h02C4, 32'h0,         32'h0000_000F}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_we = 1'b0;
    logic [15:0]    req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic           rsp_valid;
    logic [31:0]    rsp_rdata;
    logic [NP-1:0]  pin_in = '0;
    logic [NP-1:0]  pin_out;
    logic [NP-1:0]  pin_oe;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_banked dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic bus_op(input logic we, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] r);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        check("R1 rsp_valid", 128'(rsp_valid), 128'(1));
        r = rsp_rdata;
        req_valid = 1'b0;
        req_we    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 pin_out", 128'(pin_out), 128'(0));
        check("R10 pin_oe", 128'(pin_oe), 128'(0));
        check("R10 rsp_valid", 128'(rsp_valid), 128'(0));
        bus_op(1'b0, 16'h0204, 32'h0, rd);
        check("R8 R10 dir0 reset", 128'(rd), 128'(32'h180));
        bus_op(1'b0, 16'h0208, 32'h0, rd);
        check("R10 oe0 reset", 128'(rd), 128'(0));

        for (int v = 0; v < NV; v++) begin
            bus_op(VEC[v][80], VEC[v][79:64], VEC[v][63:32], rd);
            n_checks++;
            if (rd !== VEC[v][31:0]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                         VEC[v][84:81], v, rd, VEC[v][31:0]);
            end
        end
        @(negedge clk);
        check("R1 rsp idle", 128'(rsp_valid), 128'(0));

        // R6 drive gating after the table
        check("R6 bank0 out lo", 128'(pin_out[15:0]), 128'(16'hA5A4));
        check("R6 bank0 out hi", 128'(pin_out[25:16]), 128'(10'h3FF));
        check("R6 bank0 oe off", 128'(pin_oe[25:0]), 128'(0));
        check("R6 R7 bank3 oe", 128'(pin_oe[83:52]), 128'(32'h0000_000F));
        check("R7 bank3 out hi", 128'(pin_out[83:68]), 128'(16'h1234));

        // R7 bank 1 pin 0 -> global 26
        bus_op(1'b1, 16'h0244, 32'h1, rd);
        bus_op(1'b1, 16'h0008, 32'h1, rd);
        check("R7 global26 out", 128'(pin_out[51:26]), 128'(1));
        check("R7 global26 oe", 128'(pin_oe[51:26]), 128'(1));

        // R7 bank 4 pin 0 -> global 84
        bus_op(1'b1, 16'h0304, 32'h1, rd);
        bus_op(1'b1, 16'h0308, 32'h1, rd);
        bus_op(1'b1, 16'h0020, 32'h1, rd);
        check("R7 global84 out", 128'(pin_out[115:84]), 128'(1));
        check("R7 global84 oe", 128'(pin_oe[115:84]), 128'(1));

        // R4 synchronizer latency: bank 4 pin 5 = global 89
        pin_in[89] = 1'b1;
        bus_op(1'b0, 16'h0070, 32'h0, rd);
        check("R4 edge1", 128'(rd), 128'(0));
        bus_op(1'b0, 16'h0070, 32'h0, rd);
        check("R4 edge2", 128'(rd), 128'(0));
        bus_op(1'b0, 16'h0070, 32'h0, rd);
        check("R4 edge3", 128'(rd), 128'(32'h20));
        pin_in[7] = 1'b1;
        pin_in[25] = 1'b1;
        repeat (3) @(negedge clk);
        bus_op(1'b0, 16'h0060, 32'h0, rd);
        check("R4 bank0 inputs", 128'(rd), 128'(32'h0200_0080));

        // R10 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out after reset", 128'(pin_out), 128'(0));
        check("R10 oe after reset", 128'(pin_oe), 128'(0));
        bus_op(1'b0, 16'h0204, 32'h0, rd);
        check("R8 dir0 after reset", 128'(rd), 128'(32'h180));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule